// File: doc/BRIEF.md
# PLL Configuration and Lock-Wait Controller

This block is a register-level model of the control side of an application-processor PLL. Software or a hardware sequencer writes a 32-bit configuration word that carries an enable bit and three divider fields (feedback multiplier M, pre-divider P and post-divider exponent S). A separate lock-time register holds a count of reference-clock cycles. Every configuration write drops the lock indication and restarts a countdown from the stored lock time. When the countdown completes, the lock bit in the configuration readback goes high, and a poller waiting on that bit can move on.

The block also computes the nominal output frequency in kHz from the stored divider fields and the reference frequency parameter. This is a checking aid: no clock is generated, and there is no model of the oscillator, jitter or analog settling. The lock time is meant to be programmed before the divider word that depends on it. A lock-time write therefore never alters a countdown that is already running.

Top module: `pll_cfg_lock`

## Requirements
- R1: After reset the readback word is 0, `locked` is 0, `freqKhz` is 0 and the lock-time register holds `LOCK_RESET` (0x2CF by default, 30 us at a 24 MHz reference).
- R2: A configuration write stores the enable bit from bit 31, M from bits [25:16], P from bits [13:8] and S from bits [2:0]. From the edge after the write they read back at the same positions, and bits 30, 28:26, 15:14 and 7:3 always read 0.
- R3: Readback bit 29 always equals the `locked` output.
- R4: A write with the enable bit set clears `locked` at its own edge. Let L be the lock time stored before that edge. `locked` then rises at the (L+1)-th clock edge after the write edge and stays high until the next configuration write.
- R5: A configuration write made while a countdown is running restarts the countdown from the full lock time.
- R6: With a lock time of 0, `locked` rises on the first edge after the enabled write.
- R7: A write with the enable bit clear holds the counter, and `locked` stays 0 until the next enabled write.
- R8: A lock-time write affects only configuration writes made after it. When both writes fall in the same cycle, the configuration write uses the previously stored lock time.
- R9: `freqKhz` is the truncated value of M*Fin/(P*2^(S-1)) for S>=1, and twice the truncated value of M*Fin/P for S=0. It is 0 while the stored enable bit is 0 or P is 0. It follows the stored fields without delay. Examples: M=125,P=3,S=1 gives 1000000 and M=100,P=3,S=1 gives 800000 at Fin=24000 kHz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 32 | Configuration word to write |
| lockWrEn | input | 1 | Lock-time write strobe |
| lockWrData | input | LOCK_W | Lock time in reference cycles |
| cfgRdData | output | 32 | Configuration readback including lock bit 29 |
| locked | output | 1 | Lock status |
| freqKhz | output | FREQ_W | Nominal output frequency in kHz |

## Verification
Readback fields and `freqKhz` are due right after the write edge. `locked` falls at that same edge and rises exactly L+1 edges later. The bench's behavioural model applies each write at the clock edge and keeps a countdown integer. The outputs are compared on every falling edge, so each result is taken one half-period after the edge that produced it. The directed checks count falling edges from the write: sampling after L edges must show 0 and after L+1 edges must show 1. This pins the rise to one exact cycle for the restart, zero-time, disabled and same-cycle lock-time cases.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;

  // Configuration word geometry (software-visible; positions are behaviour)
  localparam int CFG_W    = 32;
  localparam int EN_BIT   = 31;
  localparam int LOCK_BIT = 29;
  localparam int M_LSB    = 16;
  localparam int M_W      = 10;
  localparam int P_LSB    = 8;
  localparam int P_W      = 6;
  localparam int S_LSB    = 0;
  localparam int S_W      = 3;

  typedef struct packed {
    logic           en;
    logic [M_W-1:0] m;
    logic [P_W-1:0] p;
    logic [S_W-1:0] s;
  } pllFields_t;

  typedef struct packed {
    logic captureCfg;
    logic captureLock;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    LK_IDLE  = 2'd0,
    LK_COUNT = 2'd1,
    LK_DONE  = 2'd2
  } lockState_t;

  function automatic pllFields_t unpackCfg(input logic [CFG_W-1:0] word);
    pllFields_t f;
    f.en = word[EN_BIT];
    f.m  = word[M_LSB +: M_W];
    f.p  = word[P_LSB +: P_W];
    f.s  = word[S_LSB +: S_W];
    return f;
  endfunction

endpackage

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl
  import pll_cfg_pkg::*;
#(
  parameter int LOCK_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              reqEnable,
  input  logic              lockWrEn,
  input  logic [LOCK_W-1:0] lockTime,
  output ctrlStrobe_t       strobe,
  output logic              locked
);

  lockState_t        state;
  logic [LOCK_W-1:0] count;
  logic              countDone;

  assign countDone = (count == '0);

  always_comb begin
    strobe.captureCfg  = cfgWrEn;
    strobe.captureLock = lockWrEn;
  end

  // Every configuration write restarts the wait from the stored lock time.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= LK_IDLE;
      count <= '0;
    end else if (cfgWrEn) begin
      count <= lockTime;
      state <= reqEnable ? LK_COUNT : LK_IDLE;
    end else if (state == LK_COUNT) begin
      if (countDone) state <= LK_DONE;
      else           count <= count - 1'b1;
    end
  end

  assign locked = (state == LK_DONE);

endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc
  import pll_cfg_pkg::*;
#(
  parameter int FIN_KHZ = 24000,
  parameter int FREQ_W  = 32
) (
  input  pllFields_t        fields,
  output logic [FREQ_W-1:0] freqKhz
);

  localparam int FIN_W = $clog2(FIN_KHZ + 1);
  localparam int NUM_W = M_W + FIN_W;

  logic [NUM_W-1:0] product;
  logic [NUM_W-1:0] quotient;
  logic [FREQ_W-1:0] widened;

  assign product  = NUM_W'(fields.m) * NUM_W'(FIN_KHZ);
  assign quotient = (fields.p == '0) ? '0 : product / NUM_W'(fields.p);
  assign widened  = FREQ_W'(quotient);

  always_comb begin
    if (!fields.en || fields.p == '0)
      freqKhz = '0;
    else if (fields.s == '0)
      freqKhz = widened << 1;
    else
      freqKhz = widened >> (fields.s - 1'b1);
  end

endmodule

// File: rtl/pll_cfg_datapath.sv
module pll_cfg_datapath
  import pll_cfg_pkg::*;
#(
  parameter int                LOCK_W     = 16,
  parameter logic [LOCK_W-1:0] LOCK_RESET = 'h2CF,
  parameter int                FIN_KHZ    = 24000,
  parameter int                FREQ_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic [LOCK_W-1:0] lockWrData,
  input  logic              lockedIn,
  output logic [LOCK_W-1:0] lockTime,
  output logic [CFG_W-1:0]  cfgRdData,
  output logic [FREQ_W-1:0] freqKhz
);

  pllFields_t cfgQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ     <= '0;
      lockTime <= LOCK_RESET;
    end else begin
      if (strobe.captureCfg)  cfgQ     <= unpackCfg(cfgWrData);
      if (strobe.captureLock) lockTime <= lockWrData;
    end
  end

  always_comb begin
    cfgRdData                  = '0;
    cfgRdData[EN_BIT]          = cfgQ.en;
    cfgRdData[LOCK_BIT]        = lockedIn;
    cfgRdData[M_LSB +: M_W]    = cfgQ.m;
    cfgRdData[P_LSB +: P_W]    = cfgQ.p;
    cfgRdData[S_LSB +: S_W]    = cfgQ.s;
  end

  pll_freq_calc #(
    .FIN_KHZ (FIN_KHZ),
    .FREQ_W  (FREQ_W)
  ) u_freq (
    .fields  (cfgQ),
    .freqKhz (freqKhz)
  );

endmodule

// File: rtl/pll_cfg_lock.sv
module pll_cfg_lock
  import pll_cfg_pkg::*;
#(
  parameter int                LOCK_W     = 16,
  parameter logic [LOCK_W-1:0] LOCK_RESET = 'h2CF,
  parameter int                FIN_KHZ    = 24000,
  parameter int                FREQ_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [31:0]       cfgWrData,
  input  logic              lockWrEn,
  input  logic [LOCK_W-1:0] lockWrData,
  output logic [31:0]       cfgRdData,
  output logic              locked,
  output logic [FREQ_W-1:0] freqKhz
);

  ctrlStrobe_t       strobe;
  logic [LOCK_W-1:0] lockTime;

  pll_lock_ctrl #(
    .LOCK_W (LOCK_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .reqEnable (cfgWrData[EN_BIT]),
    .lockWrEn  (lockWrEn),
    .lockTime  (lockTime),
    .strobe    (strobe),
    .locked    (locked)
  );

  pll_cfg_datapath #(
    .LOCK_W     (LOCK_W),
    .LOCK_RESET (LOCK_RESET),
    .FIN_KHZ    (FIN_KHZ),
    .FREQ_W     (FREQ_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgWrData  (cfgWrData),
    .lockWrData (lockWrData),
    .lockedIn   (locked),
    .lockTime   (lockTime),
    .cfgRdData  (cfgRdData),
    .freqKhz    (freqKhz)
  );

endmodule

// File: rtl/pll_cfg_lock_chk.sv
module pll_cfg_lock_chk #(
  parameter int                LOCK_W     = 16,
  parameter logic [LOCK_W-1:0] LOCK_RESET = 'h2CF,
  parameter int                FREQ_W     = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [31:0]       cfgWrData,
  input logic              lockWrEn,
  input logic [LOCK_W-1:0] lockWrData,
  input logic [31:0]       cfgRdData,
  input logic              locked,
  input logic [FREQ_W-1:0] freqKhz
);

  logic [LOCK_W-1:0] shadowLock;
  logic [LOCK_W-1:0] target;
  logic [31:0]       elapsed;
  logic              armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowLock <= LOCK_RESET;
      target     <= '0;
      elapsed    <= '0;
      armed      <= 1'b0;
    end else begin
      if (lockWrEn) shadowLock <= lockWrData;
      if (cfgWrEn) begin
        target  <= shadowLock;
        elapsed <= '0;
        armed   <= cfgWrData[31];
      end else if (elapsed != 32'hFFFF_FFFF) begin
        elapsed <= elapsed + 1;
      end
    end
  end

  AST_WRITE_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> !locked); // R4

  AST_LOCK_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> (armed && elapsed == 32'(target) + 32'd1)); // R5

  AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !cfgWrEn) |=> locked); // R4

  AST_DISABLED_NO_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !cfgWrData[31]) |=> (!locked && !cfgRdData[31])); // R7

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdData[30] == 1'b0 && cfgRdData[28:26] == 3'b0 &&
     cfgRdData[15:14] == 2'b0 && cfgRdData[7:3] == 5'b0)); // R2

  AST_FIELDS_STORED: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> (cfgRdData[25:16] == $past(cfgWrData[25:16]) &&
                 cfgRdData[13:8] == $past(cfgWrData[13:8]) &&
                 cfgRdData[2:0] == $past(cfgWrData[2:0]))); // R2

  AST_FREQ_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgRdData[31] || cfgRdData[13:8] == 6'd0) |-> (freqKhz == '0)); // R9

endmodule

bind pll_cfg_lock pll_cfg_lock_chk #(
  .LOCK_W     (LOCK_W),
  .LOCK_RESET (LOCK_RESET),
  .FREQ_W     (FREQ_W)
) u_chk (.*);

// File: tb/test_pll_cfg_lock.sv
module test_pll_cfg_lock;

  localparam int CLK_PERIOD = 10;
  localparam int LOCK_W     = 16;
  localparam int FREQ_W     = 32;
  localparam int FIN        = 24000;
  localparam int LOCK_RST   = 'h2CF;
  localparam int WATCHDOG   = 150000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWrEn = 1'b0;
  logic [31:0]       cfgWrData = '0;
  logic              lockWrEn = 1'b0;
  logic [LOCK_W-1:0] lockWrData = '0;
  logic [31:0]       cfgRdData;
  logic              locked;
  logic [FREQ_W-1:0] freqKhz;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;
  bit done    = 0;

  pll_cfg_lock i_pll_cfg_lock (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgWrData  (cfgWrData),
    .lockWrEn   (lockWrEn),
    .lockWrData (lockWrData),
    .cfgRdData  (cfgRdData),
    .locked     (locked),
    .freqKhz    (freqKhz)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  int  mEn, mM, mP, mS, mLockTime, mCount;
  bit  mLocked;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mEn = 0; mM = 0; mP = 0; mS = 0;
      mLockTime = LOCK_RST; mCount = -1; mLocked = 0;
    end else begin
      if (cfgWrEn) begin
        mEn = cfgWrData[31]; mM = cfgWrData[25:16];
        mP = cfgWrData[13:8]; mS = cfgWrData[2:0];
        mLocked = 0;
        mCount = mEn ? mLockTime : -1;
      end else if (mCount == 0) begin
        mLocked = 1; mCount = -1;
      end else if (mCount > 0) begin
        mCount = mCount - 1;
      end
      if (lockWrEn) mLockTime = lockWrData;
    end
  end

  function automatic longint expFreq();
    longint num;
    num = longint'(mM) * FIN;
    if (mEn == 0 || mP == 0) return 0;
    if (mS == 0) return 2 * (num / mP);
    return num / (longint'(mP) * (longint'(1) << (mS - 1)));
  endfunction

  function automatic longint expRd();
    return (longint'(mEn) << 31) | (longint'(mLocked) << 29) |
           (longint'(mM) << 16) | (longint'(mP) << 8) | longint'(mS);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(cfgRdData == 32'(expRd()), "R2 R3 readback", cfgRdData, expRd());
      chk(locked == mLocked, "R4 locked", locked, mLocked);
      chk(freqKhz == FREQ_W'(expFreq()), "R9 freqKhz", freqKhz, expFreq());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  task automatic writeCfg(input logic [31:0] w);
    cfgWrEn = 1'b1; cfgWrData = w;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic writeLock(input int t);
    lockWrEn = 1'b1; lockWrData = LOCK_W'(t);
    @(negedge clk);
    lockWrEn = 1'b0;
  endtask

  function automatic logic [31:0] cfgWord(input bit en, input int m, input int p, input int s);
    return {en, 5'b0, 10'(m), 2'b0, 6'(p), 5'b0, 3'(s)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(cfgRdData == 32'h0, "R1 reset readback", cfgRdData, 0);
    chk(locked == 1'b0, "R1 reset locked", locked, 0);
    chk(freqKhz == '0, "R1 reset freq", freqKhz, 0);

    // R1 reset lock time used, R4 rise timing, R9 1000 MHz
    writeCfg(cfgWord(1, 125, 3, 1));
    chk(freqKhz == 1000000, "R9 1000MHz", freqKhz, 1000000);
    repeat (LOCK_RST) @(negedge clk);
    chk(locked == 1'b0, "R1 R4 still waiting", locked, 0);
    @(negedge clk);
    chk(locked == 1'b1, "R4 locked after L+1", locked, 1);
    chk(cfgRdData[29] == 1'b1, "R3 bit 29", cfgRdData[29], 1);

    // R5: restart mid-count
    writeCfg(cfgWord(1, 100, 3, 1));
    chk(freqKhz == 800000, "R9 800MHz", freqKhz, 800000);
    repeat (100) @(negedge clk);
    writeCfg(cfgWord(1, 100, 3, 1));
    repeat (LOCK_RST) @(negedge clk);
    chk(locked == 1'b0, "R5 restarted count", locked, 0);
    @(negedge clk);
    chk(locked == 1'b1, "R5 lock after restart", locked, 1);

    // R6: zero lock time
    writeLock(0);
    writeCfg(cfgWord(1, 100, 3, 1));
    chk(locked == 1'b0, "R6 cleared on write", locked, 0);
    @(negedge clk);
    chk(locked == 1'b1, "R6 lock next edge", locked, 1);

    // R7: disabled write holds lock low
    writeCfg(cfgWord(0, 125, 3, 1));
    repeat (40) @(negedge clk);
    chk(locked == 1'b0, "R7 disabled no lock", locked, 0);
    chk(freqKhz == '0, "R7 R9 disabled freq", freqKhz, 0);

    // R8: lock-time write during count does not disturb it
    writeLock(10);
    writeCfg(cfgWord(1, 125, 3, 1));
    writeLock(40);
    repeat (9) @(negedge clk);
    chk(locked == 1'b0, "R8 old count", locked, 0);
    @(negedge clk);
    chk(locked == 1'b1, "R8 lock at 11", locked, 1);
    writeCfg(cfgWord(1, 125, 3, 1));
    repeat (40) @(negedge clk);
    chk(locked == 1'b0, "R8 new time used", locked, 0);
    @(negedge clk);
    chk(locked == 1'b1, "R8 lock at 41", locked, 1);

    // R8: same-cycle writes use the previous lock time
    writeLock(5);
    lockWrEn = 1'b1; lockWrData = 16'd20;
    writeCfg(cfgWord(1, 100, 3, 1));
    lockWrEn = 1'b0;
    repeat (5) @(negedge clk);
    chk(locked == 1'b0, "R8 same cycle pre", locked, 0);
    @(negedge clk);
    chk(locked == 1'b1, "R8 same cycle old value", locked, 1);

    // R2: reserved bits dropped
    writeCfg(32'hFFFF_FFFF);
    chk(cfgRdData == 32'h83FF_3F07, "R2 reserved zero", cfgRdData, 32'h83FF3F07);
    chk(freqKhz == 6089, "R9 max fields", freqKhz, 6089);
    repeat (25) @(negedge clk);

    // R9: S=0 and P=0 corners
    writeCfg(cfgWord(1, 50, 4, 0));
    chk(freqKhz == 600000, "R9 S zero", freqKhz, 600000);
    writeCfg(cfgWord(1, 50, 0, 2));
    chk(freqKhz == '0, "R9 P zero", freqKhz, 0);
    repeat (25) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule